// File: doc/BRIEF.md
# Direct-Mapped Write-Back Word Cache

This block places 1024 single-word lines between a processor's memory port and a slow main memory. The processor raises a request with a 20-bit word address, a write flag and, for writes, a data word. It keeps that request steady until the cache pulses done. When a read is served, the returned word sits on the read-data output during the done cycle.

Hits are served from the line storage after one lookup cycle. A read miss refills the line from memory. Writes never fetch from memory, because each line holds exactly one word. A line that is both valid and modified is copied back to memory before it is replaced. Two counters count lookups that hit and lookups that miss, so that performance can be measured.

Top module: `wb_word_cache`

## Requirements
- R1: After reset every line is invalid and unmodified, both counters read zero, and neither done nor the memory request is asserted. The first access to any line misses, whatever its address.
- R2: Address bits 9:0 select the line and bits 19:10 are the tag. Two addresses with the same bits 9:0 but different bits 19:10 evict each other.
- R3: A read hit returns the stored word with done observed two clocks after the request is first sampled, and it makes no memory access.
- R4: A read miss to a line that is not modified issues exactly one memory read (mem_we=0) of the requested address. It installs the returned word as valid and unmodified and returns that word. Done follows one clock after the memory's done.
- R5: A miss on a valid modified line first issues one memory write (mem_we=1). That write carries the old word and the address formed from the stored tag and the index. Only after it completes is anything else done.
- R6: A write hit updates only the line and marks it modified, with no memory access. Done comes two clocks after the request.
- R7: A write miss to a line that is invalid or unmodified overwrites word and tag, marks the line valid and modified, and makes no memory access. Done comes two clocks after the request.
- R8: A write miss to a valid modified line performs the write-back of R5, then installs the new word without any memory read. Done comes one clock after the write-back's memory done.
- R9: Done is a one-cycle pulse. While a memory request waits for the memory's done, the address and write flag stay unchanged.
- R10: Each lookup adds exactly one to either the hit counter or the miss counter, and neither counter changes otherwise.
- R11: A request is taken only while the controller is idle, and only one is handled at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 20 | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid during done |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request, held until mem_done |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 20 | Memory word address |
| mem_wdata | output | 32 | Word written back to memory |
| mem_rdata | input | 32 | Word returned by memory, valid with mem_done |
| mem_done | input | 1 | Memory completion pulse |
| hit_count | output | 32 | Number of lookups that hit |
| miss_count | output | 32 | Number of lookups that missed |

## Verification
The properties assume a well-behaved processor, one that holds address, write flag and data steady from request until done and drops the request right after done. They also assume a memory that pulses done once per access and only while a request is pending. The bench's processor task and memory model keep to both rules by construction. They give a fixed 100-cycle memory latency and random traffic over a few indices and tags, so the traffic covers hits, clean and dirty evictions, and both ends of the address range.

// File: rtl/wb_word_cache.sv
module wb_word_cache #(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_done,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  typedef enum logic [2:0] {IDLE, LOOKUP, WRITEBACK_WAIT, REFILL_WAIT, RESPOND} state_t;
  state_t st;

  logic [DATA_W-1:0] line_data [LINES];
  logic [TAG_W-1:0]  line_tag  [LINES];
  logic [LINES-1:0]  line_vld, line_mod;

  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  wire [IDX_W-1:0] idx    = addr_q[IDX_W-1:0];
  wire [TAG_W-1:0] tag    = addr_q[ADDR_W-1:IDX_W];
  wire             hit    = line_vld[idx] && (line_tag[idx] == tag);
  wire             victim = line_vld[idx] && line_mod[idx];

  wire fill = (st == LOOKUP && we_q && (hit || !victim))
           || (st == WRITEBACK_WAIT && mem_done && we_q)
           || (st == REFILL_WAIT && mem_done);
  wire [DATA_W-1:0] fill_word = (st == REFILL_WAIT) ? mem_rdata : wdata_q;

  assign cpu_done  = (st == RESPOND);
  assign cpu_rdata = rdata_q;
  assign mem_req   = (st == WRITEBACK_WAIT) || (st == REFILL_WAIT);
  assign mem_we    = (st == WRITEBACK_WAIT);
  assign mem_addr  = (st == WRITEBACK_WAIT) ? {line_tag[idx], idx} : addr_q;
  assign mem_wdata = line_data[idx];

  always_ff @(posedge clk) begin
    if (fill) begin
      line_data[idx] <= fill_word;
      line_tag[idx]  <= tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      line_vld   <= '0;
      line_mod   <= '0;
      we_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      if (fill) begin
        line_vld[idx] <= 1'b1;
        line_mod[idx] <= (st != REFILL_WAIT);
      end
      case (st)
        IDLE: if (cpu_req) begin
          we_q    <= cpu_we;
          addr_q  <= cpu_addr;
          wdata_q <= cpu_wdata;
          st      <= LOOKUP;
        end
        LOOKUP: begin
          if (hit) begin
            hit_count <= hit_count + 1'b1;
            if (!we_q) rdata_q <= line_data[idx];
            st <= RESPOND;
          end else begin
            miss_count <= miss_count + 1'b1;
            if (victim)    st <= WRITEBACK_WAIT;
            else if (we_q) st <= RESPOND;
            else           st <= REFILL_WAIT;
          end
        end
        WRITEBACK_WAIT: if (mem_done) st <= we_q ? RESPOND : REFILL_WAIT;
        REFILL_WAIT: if (mem_done) begin
          rdata_q <= mem_rdata;
          st      <= RESPOND;
        end
        RESPOND: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == LOOKUP && hit |=> cpu_done && !mem_req);
  p_clean_wmiss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st == LOOKUP && !hit && !victim && we_q |=> cpu_done && !mem_req);
  p_victim_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st == LOOKUP && !hit && victim |=> mem_req && mem_we);
  p_wb_then_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st == WRITEBACK_WAIT && mem_done && !we_q |=> mem_req && !mem_we);
  p_wb_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st == WRITEBACK_WAIT && mem_done && we_q |=> cpu_done && !mem_req);
  p_counts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st != LOOKUP |=> $stable(hit_count) && $stable(miss_count));
  p_one_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st != IDLE && st != RESPOND |=> $stable(addr_q));
endmodule

// File: tb/tb_wb_word_cache.sv
`timescale 1ns/1ps
module tb_wb_word_cache;
  localparam int LAT = 100;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [19:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic        cpu_done, mem_req, mem_we, mem_done = 1'b0;
  logic [19:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0, hit_count, miss_count;

  wb_word_cache dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_done(mem_done), .hit_count(hit_count), .miss_count(miss_count));

  initial forever #10 clk = ~clk;

  int checks = 0, errors = 0, n_rd = 0, n_wr = 0, exp_hits = 0, exp_miss = 0;
  logic [31:0] phys [int];
  logic [31:0] arch [int];
  bit          rv [1024];
  bit          rm [1024];
  logic [9:0]  rt [1024];

  function automatic logic [31:0] seed_word(logic [19:0] a);
    return ({12'd0, a} * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [31:0] arch_val(logic [19:0] a);
    return arch.exists(int'(a)) ? arch[int'(a)] : seed_word(a);
  endfunction
  function automatic int exp_latency(bit h, bit w, bit v);
    if (h) return 2;
    if (w) return v ? LAT + 3 : 2;
    return v ? 2 * LAT + 4 : LAT + 3;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    if (!rst_n) mem_done <= 1'b0;
    else if (mem_req && !mem_done) begin : mem_step
      static int cnt = 0;
      if (cnt == LAT - 1) begin
        cnt = 0;
        mem_done <= 1'b1;
        if (mem_we) begin
          n_wr++;
          check(mem_wdata == arch_val(mem_addr), "R5", "write-back data", mem_wdata, arch_val(mem_addr));
          phys[int'(mem_addr)] = mem_wdata;
        end else begin
          n_rd++;
          mem_rdata <= phys.exists(int'(mem_addr)) ? phys[int'(mem_addr)] : seed_word(mem_addr);
        end
      end else cnt++;
    end else mem_done <= 1'b0;
  end

  task automatic access(bit w, logic [19:0] a, logic [31:0] d);
    logic [9:0] ix = a[9:0];
    bit h = rv[ix] && rt[ix] == a[19:10];
    bit v = !h && rv[ix] && rm[ix];
    int rd0 = n_rd, wr0 = n_wr, cyc = 0;
    int lat = exp_latency(h, w, v);
    logic [31:0] expd = arch_val(a);
    string rq = h ? (w ? "R6" : "R3") : (w ? (v ? "R8" : "R7") : (v ? "R5" : "R4"));
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
    while (1) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (cpu_done || cyc > 3 * LAT) break;
    end
    cpu_req = 1'b0;
    check(cyc == lat, rq, "latency", cyc, lat);
    check(n_rd - rd0 == ((!h && !w) ? 1 : 0), rq, "memory reads", n_rd - rd0, (!h && !w) ? 1 : 0);
    check(n_wr - wr0 == (v ? 1 : 0), rq, "memory writes", n_wr - wr0, v ? 1 : 0);
    if (!w) check(cpu_rdata == expd, rq, "read data", cpu_rdata, expd);
    if (h) exp_hits++; else exp_miss++;
    if (w) arch[int'(a)] = d;
    if (h) rm[ix] = rm[ix] | w;
    else begin rv[ix] = 1'b1; rt[ix] = a[19:10]; rm[ix] = w; end
    @(negedge clk);
    check(!cpu_done, "R9", "done pulse width", cpu_done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd535));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cpu_done && !mem_req, "R1", "outputs idle after reset", {cpu_done, mem_req}, 0);
    check(hit_count == 0 && miss_count == 0, "R1", "counters cleared", hit_count + miss_count, 0);
    access(0, 20'h00000, 0);            // R1 invalid line with matching zero tag misses
    access(0, 20'h00000, 0);            // R3 hit
    access(1, 20'h00400, 32'hA1A1A1A1); // R2 same index other tag, R7 clean write miss
    access(1, 20'h00400, 32'hB2B2B2B2); // R6 write hit
    access(0, 20'h00400, 0);            // R6 hit sees written word
    access(0, 20'h00000, 0);            // R5 dirty victim then refill
    access(1, 20'h00C00, 32'hC3C3C3C3); // R7 clean line overwritten
    access(1, 20'h00800, 32'hD4D4D4D4); // R8 dirty write miss
    access(0, 20'hFFFFF, 0);            // R2 top address
    access(1, 20'hFFFFF, 32'hE5E5E5E5);
    access(0, 20'h003FF, 0);            // R2 same index as top, tag zero
    access(0, 20'hFFFFF, 0);
    for (int i = 0; i < 400; i++) begin
      logic [9:0] ix = ($urandom % 4 == 0) ? 10'h3FF : 10'($urandom % 6);
      logic [9:0] tg = ($urandom % 5 == 0) ? 10'h3FF : 10'($urandom % 4);
      access(1'($urandom % 2), {tg, ix}, $urandom);
    end
    check(hit_count == exp_hits, "R10", "hit counter", hit_count, exp_hits);
    check(miss_count == exp_miss, "R10", "miss counter", miss_count, exp_miss);
    check(!mem_req && !cpu_done, "R11", "idle after last request", {mem_req, cpu_done}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule